// File: doc/BRIEF.md
# Split-Register Wide-Bank Cartridge Controller

This block maps a 16-bit CPU address space onto a large ROM and a banked RAM. The 0x0000–0x3FFF window always points at the first 16 KiB of ROM. The 0x4000–0x7FFF window points at a switchable ROM bank. The 0xA000–0xBFFF window points at one of up to sixteen 8 KiB RAM banks. The ROM bank number is 9 bits wide, so up to 512 banks of 16 KiB can be reached. Software sets it through two separate register ranges: one takes a full byte for the low eight bits, the other takes a single bit for bit 8. Bank zero is not redirected. It may be selected in the switchable window like any other bank.

The CPU side is an address, a write data byte and a write strobe. Writes below 0x6000 load the bank registers, and the new values take effect from the next clock. The memory side is combinational from the current address and the registered bank state. It provides a physical ROM address and a ROM select, a RAM address with select and write enable, a flag that tells the data path to return zero for the read, and a flag for a bank number beyond the configured bank count. The configured ROM and RAM bank counts are parameters.

Top module: `cbc_bank_ctrl`

## Requirements
- R1: After reset the switchable ROM bank is 1, the RAM bank is 0 and RAM is disabled.
- R2: A write anywhere in 0x0000–0x1FFF enables RAM when the data is 0x0A and disables it for any other value.
- R3: A write in 0x2000–0x2FFF loads the whole data byte into ROM bank bits 7:0 and leaves bank bit 8 unchanged.
- R4: A write in 0x3000–0x3FFF loads data bit 0 into ROM bank bit 8 and leaves bank bits 7:0 unchanged.
- R5: Writing 0x00 to the low ROM bank register makes the switchable window read bank 0, at physical ROM address (addr − 0x4000).
- R6: A write in 0x4000–0x5FFF loads data bits 3:0 into the RAM bank and ignores data bits 7:4.
- R7: A read in 0x0000–0x3FFF asserts rom_cs with rom_addr equal to the CPU address, whatever the bank state.
- R8: A read in 0x4000–0x7FFF gives rom_addr = bank × 0x4000 + (addr − 0x4000). It asserts rom_cs when the bank is below ROM_BANKS. Otherwise rom_cs stays low and both zero_fill and range_err are raised.
- R9: An access in 0xA000–0xBFFF gives ram_addr = RAM bank × 0x2000 + (addr − 0xA000). When RAM is enabled and the bank is below RAM_BANKS, ram_cs is asserted, and ram_we also is asserted for a write.
- R10: A RAM access whose bank is at or above RAM_BANKS raises range_err and never asserts ram_cs or ram_we. A read in that state also raises zero_fill.
- R11: While RAM is disabled and the bank is in range, a RAM read raises zero_fill, a RAM write is dropped (ram_we low), and range_err stays low.
- R12: Writes in 0x6000–0x7FFF and outside all decoded ranges change no bank state, and a write never asserts rom_cs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | Write strobe; low means read |
| rom_addr | output | 23 | Physical ROM byte address |
| rom_cs | output | 1 | ROM read select |
| ram_addr | output | 17 | Physical RAM byte address |
| ram_cs | output | 1 | RAM select (enabled, bank in range) |
| ram_we | output | 1 | RAM write enable |
| zero_fill | output | 1 | Read data must be forced to zero |
| range_err | output | 1 | Selected bank lies beyond the configured count |

## Verification
The hardest situation to reach is a ninth-bit ROM bank that lies beyond the configured count. Only a sequence of separate writes to both ROM bank registers produces it. The same is true of bank 0 selected through the low register while bit 8 is set or clear. The bench is built with fewer ROM and RAM banks than the register fields can address. It writes the low and high ROM registers in alternating orders, and then walks a pseudo-random mix of register writes and window accesses, so that out-of-range banks occur next to in-range ones. A behavioural model tracks the registers and predicts every output on every cycle.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

    localparam int CPU_AW     = 16;
    localparam int CPU_DW     = 8;
    localparam int ROM_BANK_W = 9;
    localparam int RAM_BANK_W = 4;
    localparam int ROM_OFS_W  = 14;
    localparam int RAM_OFS_W  = 13;
    localparam int ROM_AW     = ROM_BANK_W + ROM_OFS_W;
    localparam int RAM_AW     = RAM_BANK_W + RAM_OFS_W;

    localparam logic [CPU_DW-1:0] RAM_UNLOCK = 8'h0A;

    typedef enum logic [1:0] {
        WIN_NONE,
        WIN_ROM_FIXED,
        WIN_ROM_BANKED,
        WIN_RAM
    } win_e;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_RAM_GATE,
        TGT_ROM_LO,
        TGT_ROM_HI,
        TGT_RAM_SEL
    } target_e;

    typedef struct packed {
        win_e    win;
        target_e target;
    } decode_t;

    typedef struct packed {
        logic [ROM_BANK_W-1:0] rom_bank;
        logic [RAM_BANK_W-1:0] ram_bank;
        logic                  ram_on;
    } bank_state_t;

    // Decode from the top address nibble: which window a read hits and
    // which register a write loads.
    function automatic decode_t decode_nibble(input logic [3:0] nib);
        decode_t d;
        d.win    = WIN_NONE;
        d.target = TGT_NONE;
        case (nib)
            4'h0, 4'h1: begin d.win = WIN_ROM_FIXED;  d.target = TGT_RAM_GATE; end
            4'h2:       begin d.win = WIN_ROM_FIXED;  d.target = TGT_ROM_LO;   end
            4'h3:       begin d.win = WIN_ROM_FIXED;  d.target = TGT_ROM_HI;   end
            4'h4, 4'h5: begin d.win = WIN_ROM_BANKED; d.target = TGT_RAM_SEL;  end
            4'h6, 4'h7: begin d.win = WIN_ROM_BANKED; d.target = TGT_NONE;     end
            4'hA, 4'hB: begin d.win = WIN_RAM;        d.target = TGT_NONE;     end
            default:    begin d.win = WIN_NONE;       d.target = TGT_NONE;     end
        endcase
        return d;
    endfunction

endpackage

// File: rtl/cbc_decode.sv
module cbc_decode
    import cbc_pkg::*;
(
    input  logic [3:0] addr_nib,
    output decode_t    dec
);
    always_comb begin
        dec = decode_nibble(addr_nib);
    end
endmodule

// File: rtl/cbc_bank_regs.sv
module cbc_bank_regs
    import cbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  target_e           target,
    input  logic [CPU_DW-1:0] wdata,
    output bank_state_t       state
);
    bank_state_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.rom_bank <= ROM_BANK_W'(1);
            st_q.ram_bank <= '0;
            st_q.ram_on   <= 1'b0;
        end else if (we) begin
            case (target)
                TGT_RAM_GATE: st_q.ram_on        <= (wdata == RAM_UNLOCK);
                TGT_ROM_LO:   st_q.rom_bank[7:0] <= wdata;
                TGT_ROM_HI:   st_q.rom_bank[8]   <= wdata[0];
                TGT_RAM_SEL:  st_q.ram_bank      <= wdata[RAM_BANK_W-1:0];
                default:      st_q               <= st_q;
            endcase
        end
    end

    assign state = st_q;
endmodule

// File: rtl/cbc_map.sv
module cbc_map
    import cbc_pkg::*;
#(
    parameter int ROM_BANKS = 512,
    parameter int RAM_BANKS = 16
) (
    input  logic [ROM_OFS_W-1:0] offset,
    input  logic                 we,
    input  win_e                 win,
    input  bank_state_t          state,
    output logic [ROM_AW-1:0]    rom_addr,
    output logic                 rom_cs,
    output logic [RAM_AW-1:0]    ram_addr,
    output logic                 ram_cs,
    output logic                 ram_we,
    output logic                 zero_fill,
    output logic                 range_err
);
    localparam int ROM_FULL = 1 << ROM_BANK_W;
    localparam int RAM_FULL = 1 << RAM_BANK_W;
    localparam logic [ROM_BANK_W:0] ROM_LIMIT = (ROM_BANK_W+1)'(ROM_BANKS);
    localparam logic [RAM_BANK_W:0] RAM_LIMIT = (RAM_BANK_W+1)'(RAM_BANKS);

    logic rom_ok;
    logic ram_ok;

    // A full-size configuration needs no comparator at all.
    generate
        if (ROM_BANKS >= ROM_FULL) begin : g_rom_full
            assign rom_ok = 1'b1;
        end else begin : g_rom_cmp
            assign rom_ok = ({1'b0, state.rom_bank} < ROM_LIMIT);
        end
        if (RAM_BANKS >= RAM_FULL) begin : g_ram_full
            assign ram_ok = 1'b1;
        end else begin : g_ram_cmp
            assign ram_ok = ({1'b0, state.ram_bank} < RAM_LIMIT);
        end
    endgenerate

    logic in_fixed, in_banked, in_ram;

    always_comb begin
        in_fixed  = (win == WIN_ROM_FIXED);
        in_banked = (win == WIN_ROM_BANKED);
        in_ram    = (win == WIN_RAM);

        if (in_banked) begin
            rom_addr = {state.rom_bank, offset};
        end else begin
            rom_addr = {{ROM_BANK_W{1'b0}}, offset};
        end
        rom_cs = !we && (in_fixed || (in_banked && rom_ok));

        ram_addr = {state.ram_bank, offset[RAM_OFS_W-1:0]};
        ram_cs   = in_ram && state.ram_on && ram_ok;
        ram_we   = ram_cs && we;

        zero_fill = !we && ((in_banked && !rom_ok) ||
                            (in_ram && !(state.ram_on && ram_ok)));
        range_err = (!we && in_banked && !rom_ok) || (in_ram && !ram_ok);
    end
endmodule

// File: rtl/cbc_bank_ctrl.sv
module cbc_bank_ctrl
    import cbc_pkg::*;
#(
    parameter int ROM_BANKS = 512,
    parameter int RAM_BANKS = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] cpu_addr,
    input  logic [7:0]  cpu_wdata,
    input  logic        cpu_we,
    output logic [22:0] rom_addr,
    output logic        rom_cs,
    output logic [16:0] ram_addr,
    output logic        ram_cs,
    output logic        ram_we,
    output logic        zero_fill,
    output logic        range_err
);
    decode_t     dec;
    bank_state_t bank_st;
    logic [ROM_BANK_W-1:0] rom_bank_now;
    logic [RAM_BANK_W-1:0] ram_bank_now;
    logic                  ram_on_now;

    cbc_decode u_decode (
        .addr_nib (cpu_addr[15:12]),
        .dec      (dec)
    );

    cbc_bank_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (cpu_we),
        .target (dec.target),
        .wdata  (cpu_wdata),
        .state  (bank_st)
    );

    cbc_map #(
        .ROM_BANKS (ROM_BANKS),
        .RAM_BANKS (RAM_BANKS)
    ) u_map (
        .offset    (cpu_addr[ROM_OFS_W-1:0]),
        .we        (cpu_we),
        .win       (dec.win),
        .state     (bank_st),
        .rom_addr  (rom_addr),
        .rom_cs    (rom_cs),
        .ram_addr  (ram_addr),
        .ram_cs    (ram_cs),
        .ram_we    (ram_we),
        .zero_fill (zero_fill),
        .range_err (range_err)
    );

    assign rom_bank_now = bank_st.rom_bank;
    assign ram_bank_now = bank_st.ram_bank;
    assign ram_on_now   = bank_st.ram_on;
endmodule

// File: rtl/cbc_bank_ctrl_chk.sv
module cbc_bank_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] cpu_addr,
    input logic [7:0]  cpu_wdata,
    input logic        cpu_we,
    input logic [22:0] rom_addr,
    input logic        rom_cs,
    input logic        ram_cs,
    input logic        ram_we,
    input logic        zero_fill,
    input logic [8:0]  rom_bank,
    input logic [3:0]  ram_bank,
    input logic        ram_on
);
    assert_reset_bank_R1: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && !cpu_we && cpu_addr == 16'h4000) |-> (rom_addr == 23'h004000));

    assert_ram_unlock_R2: assert property (@(posedge clk) disable iff (rst)
        (cpu_we && cpu_addr < 16'h2000 && cpu_wdata == 8'h0A) |=> ram_on);

    assert_lo_keeps_hi_R3: assert property (@(posedge clk) disable iff (rst)
        (cpu_we && cpu_addr[15:12] == 4'h2) |=> (rom_bank[8] == $past(rom_bank[8])));

    assert_hi_keeps_lo_R4: assert property (@(posedge clk) disable iff (rst)
        (cpu_we && cpu_addr[15:12] == 4'h3) |=> (rom_bank[7:0] == $past(rom_bank[7:0])));

    assert_zero_blocks_cs_R8: assert property (@(posedge clk) disable iff (rst)
        zero_fill |-> (!rom_cs && !ram_cs));

    assert_write_needs_select_R9: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (ram_cs && cpu_we));

    assert_ignored_write_R12: assert property (@(posedge clk) disable iff (rst)
        (cpu_we && (cpu_addr[15:13] == 3'b011 || cpu_addr[15] == 1'b1))
        |=> ($stable(rom_bank) && $stable(ram_bank) && $stable(ram_on)));

    assert_no_rom_write_R12: assert property (@(posedge clk) disable iff (rst)
        cpu_we |-> !rom_cs);
endmodule

bind cbc_bank_ctrl cbc_bank_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_we    (cpu_we),
    .rom_addr  (rom_addr),
    .rom_cs    (rom_cs),
    .ram_cs    (ram_cs),
    .ram_we    (ram_we),
    .zero_fill (zero_fill),
    .rom_bank  (rom_bank_now),
    .ram_bank  (ram_bank_now),
    .ram_on    (ram_on_now)
);

// File: tb/cbc_bank_ctrl_bench.sv
`timescale 1ns/1ps
module cbc_bank_ctrl_bench;
    localparam int ROMN = 300;
    localparam int RAMN = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_we = 1'b0;
    logic [22:0] rom_addr;
    logic        rom_cs;
    logic [16:0] ram_addr;
    logic        ram_cs;
    logic        ram_we;
    logic        zero_fill;
    logic        range_err;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // reference model state
    int m_rom = 1;
    int m_ram = 0;
    bit m_en  = 0;

    always #10 clk = ~clk;

    cbc_bank_ctrl #(.ROM_BANKS(ROMN), .RAM_BANKS(RAMN)) u_cbc_bank_ctrl (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_we(cpu_we), .rom_addr(rom_addr), .rom_cs(rom_cs),
        .ram_addr(ram_addr), .ram_cs(ram_cs), .ram_we(ram_we),
        .zero_fill(zero_fill), .range_err(range_err)
    );

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic compare(string tag);
        int  a = int'(cpu_addr);
        bit  we = cpu_we;
        bit  banked = (a >= 'h4000 && a < 'h8000);
        bit  inram = (a >= 'hA000 && a < 'hC000);
        bit  rom_in = (m_rom < ROMN);
        bit  ram_in = (m_ram < RAMN);
        bit  e_rcs, e_mcs, e_zf, e_re;
        e_rcs = !we && ((a < 'h4000) || (banked && rom_in));
        e_mcs = inram && m_en && ram_in;
        e_zf  = !we && ((banked && !rom_in) || (inram && !(m_en && ram_in)));
        e_re  = (!we && banked && !rom_in) || (inram && !ram_in);
        if (a < 'h4000) chk(tag, "rom_addr", int'(rom_addr), a);
        else if (banked) chk(tag, "rom_addr", int'(rom_addr), m_rom * 'h4000 + (a - 'h4000));
        if (inram) chk(tag, "ram_addr", int'(ram_addr), m_ram * 'h2000 + (a - 'hA000));
        chk(tag, "rom_cs", int'(rom_cs), int'(e_rcs));
        chk(tag, "ram_cs", int'(ram_cs), int'(e_mcs));
        chk(tag, "ram_we", int'(ram_we), int'(e_mcs && we));
        chk(tag, "zero_fill", int'(zero_fill), int'(e_zf));
        chk(tag, "range_err", int'(range_err), int'(e_re));
    endtask

    task automatic model_write(int a, int d);
        if (a < 'h2000)      m_en  = (d == 'h0A);
        else if (a < 'h3000) m_rom = (m_rom & 'h100) | d;
        else if (a < 'h4000) m_rom = (m_rom & 'hFF) | ((d & 1) << 8);
        else if (a < 'h6000) m_ram = d & 'hF;
    endtask

    task automatic step(int a, int d, bit we, string tag);
        @(negedge clk);
        cpu_addr  = 16'(a);
        cpu_wdata = 8'(d);
        cpu_we    = we;
        #5;
        compare(tag);
        @(posedge clk);
        #1;
        if (we) model_write(a, d);
    endtask

    function automatic string tag_of(int a, bit we);
        if (we && a < 'h2000) return "R2";
        if (we && a < 'h3000) return "R3";
        if (we && a < 'h4000) return "R4";
        if (we && a < 'h6000) return "R6";
        if (a < 'h4000) return "R7";
        if (a < 'h8000) return we ? "R12" : "R8";
        if (a >= 'hA000 && a < 'hC000) return "R9";
        return "R12";
    endfunction

    initial begin
        #(64'd20 * 64'd200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        bit [31:0] lfsr = 32'h1ACE_B00C;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        step('h4000, 0, 0, "R1");
        step('hA000, 0, 0, "R1");
        step('h0123, 0, 0, "R7");
        step('h3FFF, 0, 0, "R7");

        step('h2000, 'h05, 1, "R3");
        step('h4ABC, 0, 0, "R3");
        step('h3000, 'h01, 1, "R4");
        step('h7FFF, 0, 0, "R4");
        step('h2FFF, 'h40, 1, "R3");
        step('h5000, 0, 0, "R8");
        step('h3FFF, 'hFE, 1, "R4");
        step('h6123, 0, 0, "R4");
        step('h2000, 'h00, 1, "R5");
        step('h4000, 0, 0, "R5");
        step('h7FFE, 0, 0, "R5");

        step('h1000, 'h0A, 1, "R2");
        step('h4000, 'hF2, 1, "R6");
        step('hA010, 'h55, 1, "R9");
        step('hBFFF, 0, 0, "R9");
        step('h5FFF, 'h07, 1, "R10");
        step('hA000, 'h11, 1, "R10");
        step('hA000, 0, 0, "R10");
        step('h4000, 'h03, 1, "R6");
        step('h0000, 'h0B, 1, "R2");
        step('hA100, 0, 0, "R11");
        step('hA100, 'h22, 1, "R11");
        step('h1FFF, 'h0A, 1, "R2");
        step('hA100, 0, 0, "R2");
        step('h1FFF, 'h00, 1, "R2");
        step('hA100, 0, 0, "R2");

        step('h6000, 'hFF, 1, "R12");
        step('h7000, 'h01, 1, "R12");
        step('h8000, 'h0A, 1, "R12");
        step('hC000, 'h0A, 1, "R12");
        step('hFFFF, 'h0A, 1, "R12");
        step('h4321, 0, 0, "R12");
        step('hA000, 0, 0, "R12");

        for (int i = 0; i < 600; i++) begin
            int a;
            int d;
            bit we;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            case (lfsr[3:0])
                4'd0, 4'd1: a = 'h0000 | int'(lfsr[16:4]);
                4'd2:       a = 'h2000 | int'(lfsr[15:4]);
                4'd3:       a = 'h3000 | int'(lfsr[15:4]);
                4'd4, 4'd5: a = 'h4000 | int'(lfsr[16:4]);
                4'd6, 4'd7: a = 'h4000 | int'(lfsr[17:4]);
                4'd8, 4'd9, 4'd10, 4'd11: a = 'hA000 | int'(lfsr[16:4]);
                default:    a = int'(lfsr[19:4]);
            endcase
            d  = lfsr[20] ? 'h0A : int'(lfsr[31:24]);
            we = lfsr[22] ^ lfsr[5];
            step(a, d, we, tag_of(a, we));
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule